// File: doc/BRIEF.md
# Gated 16-Bit Event Timer with Prescaler

The block is a 16-bit up-counter that software reaches as two byte registers, steered by a control register. Count events come either from a one-cycle internal instruction strobe or from rising edges on an external clock pin. The external pin may pass through a two-flop synchronizer, or be sampled by a single flop for lower latency. A 2-bit prescaler divides the chosen event stream by 1, 2, 4 or 8 before it reaches the counter.

Counting can also be gated by an active-low gate pin, which is synchronized inside the block. When the counter wraps from all ones to zero, a sticky overflow flag is set. An interrupt request is driven whenever that flag and its enable bit are both 1. All registers sit on a simple byte bus with a single address port: a write takes effect at the clock edge, and read data is combinational.

Top module: `gated_timer16`

## Requirements
- R1: After reset the control register (address 2) reads 0x00, the interrupt register (address 3) reads 0x00 and `irq` is low.
- R2: With control bit 0 (run) at 1 and bit 1 (source) at 0, at prescale 1:1 the counter advances by exactly one for each clock cycle in which `tick_en` is high.
- R3: Control bits 5:4 select the prescale: 00 gives one count per event, 01 one per 2, 10 one per 4 and 11 one per 8. After a counter write, the first count comes on the Nth event.
- R4: With the run bit at 0, the counter does not change, whatever `tick_en`, `ext_clk` and `gate_n` do.
- R5: With the source bit at 1, the counter counts rising edges of `ext_clk`, and `tick_en` has no effect.
- R6: With the source bit at 1 and control bit 2 at 0, a rise of `ext_clk` first seen at clock edge k changes the counter at edge k+2. With bit 2 at 1, it changes the counter at edge k. With the source bit at 0, bit 2 has no effect.
- R7: With control bit 6 (gate enable) at 1, the counter advances only while `gate_n` is low. The gate passes through a two-flop synchronizer with the same delay on both edges, so a gate held low for M cycles with `tick_en` high at 1:1 gives exactly M counts. The prescaler holds its count while the gate is closed.
- R8: A count from 0xFFFF to 0x0000 sets the overflow flag (bit 0 of address 3). The flag stays set until software writes 0 to it, and an overflow in the same cycle as such a write wins.
- R9: `irq` is high exactly when the overflow flag and the interrupt enable (bit 1 of address 3) are both 1.
- R10: Address 0 holds the counter low byte and address 1 the high byte; addresses 2 and 3 are control and interrupt. Control bit 7 always reads 0. Control bit 3 is stored and reads back, but has no effect on counting.
- R11: A write to either counter byte clears the prescaler count. When a counter write and a count fall in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal instruction-cycle strobe, one cycle per event |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| gate_n | input | 1 | Active-low count gate pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 low byte, 1 high byte, 2 control, 3 interrupt) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A lost or extra prescaler state shows up as a count that is off by one whole division, after at most eight events. Reading both counter bytes after a known number of strobes exposes it right away. A synchronizer with the wrong depth moves the first external count by whole cycles, and the bench times that latency edge by edge in both modes. A gate whose delays differ on its two edges leaves the gated count off by the difference. A flag that is not sticky, or that is cleared at the wrong moment, is visible on `irq` in the cycle after the wrap.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int PS_W = 2;

    localparam logic [1:0] A_CNT_LO = 2'd0;
    localparam logic [1:0] A_CNT_HI = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_IRQ    = 2'd3;

    // Field order follows bit positions 6 down to 0.
    typedef struct packed {
        logic            gate_en;   // bit 6
        logic [PS_W-1:0] psel;      // bits 5:4
        logic            lfo_en;    // bit 3, stored only
        logic            ext_raw;   // bit 2, 1 = skip synchronizer
        logic            ext_sel;   // bit 1, 1 = external pin
        logic            run;       // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{INIT}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tmr16_ext_edge.sv
module tmr16_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic raw_mode,
    output logic rise
);
    typedef struct packed {
        logic raw_prev;
        logic syn_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     pin_s;

    tmr16_sync #(.STAGES(STAGES), .INIT(1'b0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin),
        .q    (pin_s)
    );

    always_comb begin
        st_d.raw_prev = pin;
        st_d.syn_prev = pin_s;
        rise = raw_mode ? (pin & ~st_q.raw_prev) : (pin_s & ~st_q.syn_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [SEL_W-1:0] psel,
    output logic             pulse
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] pcnt_d, pcnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = (CW'(1) << psel) - CW'(1);
        pulse  = step && (pcnt_q >= limit);
        pcnt_d = pcnt_q;
        if (clear)      pcnt_d = '0;
        else if (pulse) pcnt_d = '0;
        else if (step)  pcnt_d = pcnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import tmr16_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ext_clk,
    input  logic              gate_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctrl;
        logic             flag;
        logic             ie;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic gate_s;
    logic ext_rise;
    logic cnt_wr;
    logic open_q;
    logic src_evt;
    logic inc;
    logic ovf;

    tmr16_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_gate_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (gate_n),
        .q    (gate_s)
    );

    tmr16_ext_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (ext_clk),
        .raw_mode(st_q.ctrl.ext_raw),
        .rise    (ext_rise)
    );

    tmr16_prescaler #(.SEL_W(PS_W)) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_wr),
        .step (open_q && src_evt),
        .psel (st_q.ctrl.psel),
        .pulse(inc)
    );

    always_comb begin
        cnt_wr  = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
        open_q  = st_q.ctrl.run && (!st_q.ctrl.gate_en || !gate_s);
        src_evt = st_q.ctrl.ext_sel ? ext_rise : tick_en;
        ovf     = inc && !cnt_wr && (st_q.cnt == {CNT_W{1'b1}});

        st_d = st_q;
        if (cnt_wr) begin
            if (addr == A_CNT_LO) st_d.cnt[BYTE_W-1:0]     = wdata;
            else                  st_d.cnt[CNT_W-1:BYTE_W] = wdata;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (wr_en && addr == A_CTRL) st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        if (wr_en && addr == A_IRQ) begin
            st_d.flag = wdata[0];
            st_d.ie   = wdata[1];
        end
        if (ovf) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            A_CNT_LO: rdata = st_q.cnt[BYTE_W-1:0];
            A_CNT_HI: rdata = st_q.cnt[CNT_W-1:BYTE_W];
            A_CTRL:   rdata = {{(BYTE_W-CTRL_W){1'b0}}, st_q.ctrl};
            default:  rdata = {{(BYTE_W-2){1'b0}}, st_q.ie, st_q.flag};
        endcase
        irq = st_q.flag && st_q.ie;
    end
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             gate_en,
    input logic             gate_s,
    input logic             cnt_wr,
    input logic             flag,
    input logic             irq
);
    assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && gate_en && gate_s && !cnt_wr) |=> $stable(cnt));

    assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt == {CNT_W{1'b1}}) |=> (cnt != '0 || flag));

    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind gated_timer16 tmr16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (st_q.cnt),
    .run    (st_q.ctrl.run),
    .gate_en(st_q.ctrl.gate_en),
    .gate_s (gate_s),
    .cnt_wr (cnt_wr),
    .flag   (st_q.flag),
    .irq    (irq)
);

// File: tb/tb_gated_timer16.sv
module tb_gated_timer16;
    localparam logic [7:0] C_RUN = 8'h01, C_EXT = 8'h02, C_RAW = 8'h04,
                           C_LFO = 8'h08, C_GATE = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, ext_clk = 1'b0, gate_n = 1'b1, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    int         total = 0, bad = 0, cyc = 0;
    logic [15:0] v;
    int         t;

    gated_timer16 dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk(ext_clk),
        .gate_n(gate_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    always #10 clk = ~clk;

    function automatic logic [7:0] ps(input int p);
        return 8'(p << 4);
    endfunction

    function automatic logic [15:0] expect_cnt(input logic [15:0] start, input int ev, input int p);
        return start + 16'(ev >> p);
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic rd16(output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(2'd0, lo); rd(2'd1, hi);
        d = {hi, lo};
    endtask

    task automatic load(input logic [15:0] val);
        wr(2'd0, val[7:0]);
        wr(2'd1, val[15:8]);
    endtask

    task automatic run_ticks(input int n, input bit rnd, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = rnd ? 1'($urandom % 2) : 1'b1;
            if (tick_en) cnt++;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                bad++; total++;
                $display("FAIL watchdog R0 actual=hung expected=finished");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd2, b); check("R1 ctrl", 16'(b), 16'h00);
        rd(2'd3, b); check("R1 irqreg", 16'(b), 16'h00);
        check("R1 irq", 16'(irq), 16'h0);

        // R2 internal strobe, random density
        load(16'h1234);
        wr(2'd2, C_RUN);
        run_ticks(30, 1'b1, t);
        wr(2'd2, 8'h00);
        rd16(v); check("R2 internal count", v, expect_cnt(16'h1234, t, 0));

        // R3 every prescale
        for (int p = 0; p < 4; p++) begin
            load(16'h0000);
            wr(2'd2, C_RUN | ps(p));
            run_ticks(24, 1'b0, t);
            wr(2'd2, 8'h00);
            rd16(v); check($sformatf("R3 prescale sel %0d", p), v, expect_cnt(16'h0, 24, p));
        end

        // R4 stopped timer ignores everything
        load(16'h0050);
        wr(2'd2, C_GATE | C_EXT);
        gate_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ext_clk = ~ext_clk; tick_en = 1'b1;
        end
        @(negedge clk); tick_en = 1'b0; ext_clk = 1'b0; gate_n = 1'b1;
        idle(4);
        rd16(v); check("R4 off holds", v, 16'h0050);

        // R5 external source, synchronized, tick_en ignored
        load(16'h0000);
        wr(2'd2, C_RUN | C_EXT);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); ext_clk = 1'b1; tick_en = 1'b1;
            @(negedge clk); @(negedge clk); ext_clk = 1'b0;
            @(negedge clk);
        end
        tick_en = 1'b0;
        idle(5);
        rd16(v); check("R5 ext edges", v, 16'd7);

        // R6 latency, unsynchronized
        load(16'h0000);
        wr(2'd2, C_RUN | C_EXT | C_RAW);
        ext_clk = 1'b1;
        @(negedge clk);
        rd16(v); check("R6 raw latency", v, 16'd1);
        ext_clk = 1'b0;
        idle(4);
        // R6 latency, synchronized
        load(16'h0000);
        wr(2'd2, C_RUN | C_EXT);
        ext_clk = 1'b1;
        idle(2);
        rd16(v); check("R6 sync not yet", v, 16'd0);
        idle(1);
        rd16(v); check("R6 sync third edge", v, 16'd1);
        ext_clk = 1'b0;
        idle(4);
        // R6 raw bit ignored with internal source
        load(16'h0100);
        wr(2'd2, C_RUN | C_RAW);
        run_ticks(10, 1'b0, t);
        wr(2'd2, 8'h00);
        rd16(v); check("R6 raw ignored internal", v, 16'h010A);

        // R7 gate
        load(16'h0000);
        wr(2'd2, C_RUN | C_GATE);
        run_ticks(10, 1'b0, t);
        rd16(v); check("R7 gate closed", v, 16'd0);
        tick_en = 1'b1;
        @(negedge clk); gate_n = 1'b0;
        idle(9);
        gate_n = 1'b1;
        idle(5);
        tick_en = 1'b0;
        wr(2'd2, 8'h00);
        rd16(v); check("R7 gated count", v, 16'd9);

        // R8 overflow flag, R9 irq
        wr(2'd3, 8'h00);
        load(16'hFFFF);
        wr(2'd2, C_RUN);
        run_ticks(1, 1'b0, t);
        rd16(v); check("R8 wrap value", v, 16'h0000);
        rd(2'd3, b); check("R8 flag set", 16'(b), 16'h01);
        check("R9 irq masked", 16'(irq), 16'h0);
        run_ticks(3, 1'b0, t);
        rd(2'd3, b); check("R8 flag sticky", 16'(b), 16'h01);
        wr(2'd3, 8'h03);
        check("R9 irq raised", 16'(irq), 16'h1);
        wr(2'd3, 8'h02);
        check("R9 irq cleared", 16'(irq), 16'h0);
        rd(2'd3, b); check("R8 flag cleared", 16'(b), 16'h02);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);

        // R10 bus map, bit 7 reads 0, bit 3 inert
        wr(2'd2, 8'hF8);
        rd(2'd2, b); check("R10 ctrl readback", 16'(b), 16'h78);
        load(16'hA55A);
        rd(2'd0, b); check("R10 low byte", 16'(b), 16'h5A);
        rd(2'd1, b); check("R10 high byte", 16'(b), 16'hA5);
        load(16'h0000);
        wr(2'd2, C_RUN | C_LFO);
        run_ticks(6, 1'b0, t);
        wr(2'd2, 8'h00);
        rd16(v); check("R10 lfo bit inert", v, 16'd6);

        // R11 write clears prescaler; write wins over count
        load(16'h0000);
        wr(2'd2, C_RUN | ps(3));
        run_ticks(5, 1'b0, t);
        wr(2'd0, 8'h00);
        run_ticks(7, 1'b0, t);
        rd16(v); check("R11 prescaler cleared", v, 16'd0);
        run_ticks(1, 1'b0, t);
        rd16(v); check("R11 eighth event", v, 16'd1);
        wr(2'd2, C_RUN);
        @(negedge clk);
        tick_en = 1'b1; addr = 2'd0; wdata = 8'h10; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        rd16(v); check("R11 write wins", v, 16'h0010);
        wr(2'd2, 8'h00);

        // random sweep over start value, prescale and strobe pattern (R2 R3)
        for (int k = 0; k < 12; k++) begin
            logic [15:0] st;
            int p;
            st = 16'($urandom % 16'hF000);
            p  = int'($urandom % 4);
            load(st);
            wr(2'd2, C_RUN | ps(p));
            run_ticks(20 + int'($urandom % 40), 1'b1, t);
            wr(2'd2, 8'h00);
            rd16(v); check($sformatf("R3 random %0d", k), v, expect_cnt(st, t, p));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule